// File: doc/BRIEF.md
# Processor Control Register Bank

This block holds the 64-bit internal control registers of a processor core: scratch slots, a trap-handler base, machine control, the trap return address, the asynchronous-trap request and enable masks, the processor mode fields, instruction control, the page-table base pointers, cache control fields, the address-space identifiers, the exception status pair and a cycle counter. Privileged code reaches them by index through one synchronous port. Each request names an index, a direction and, for writes, a 64-bit value.

Each register keeps only the bits its write mask allows. Some registers clear on any write. Some are read-only or write-only. A separate set of write-only indices drives translation-buffer invalidate strobes for the data side and for the instruction side. The single-entry strobe also carries the written address and the address-space number currently stored for that side. The cycle-counter index combines a stored upper half with a free-running counter for its lower half.

Read data and the error flag are registered. Both appear one cycle after the request. An access in the wrong direction, or to an index with no register, raises the error flag and changes no state.

Top module: `core_ctl_regs`

## Requirements
- R1: After reset every register reads zero, except index 9 (machine control), which reads 0x6, and index 8 (handler base), which reads the parameter PAL_BASE_RST (default 0x8000).
- R2: A write to index 10 (trap return address) stores the value with bit 1 forced to zero.
- R3: Indices 11 and 12 (trap request and enable) keep only bits 3:0. Indices 13 and 14 (instruction and data mode) keep only the bits of mask 0x18.
- R4: Write masks: index 15 (instruction control) 0xffffff0300; indices 16 and 17 (page-table bases) 0xffffffffc0000000; index 18 (cache test) 0x1ffb; indices 19 and 20 (cache and miss modes) 0x3f; index 21 (instruction ASN) 0x7f0; index 22 (data ASN) 0xfe00000000000000.
- R5: Any write to index 23 or index 24 (exception summary and exception mask) leaves that register zero, whatever the value written.
- R6: A read of index 25 returns the stored bits 63:32 in bits 63:32 and a free-running 32-bit cycle count in bits 31:0. The count advances by one on every clock.
- R7: A write to index 26 (read-only fault id) raises err_o and changes no state. A read of any write-only index 27..32 raises err_o and returns zero.
- R8: Any access to an index of 33 or above raises err_o, returns zero on a read and changes no register.
- R9: A write to index 27 or 30 pulses inv_all_o for one cycle. A write to index 28 or 31 pulses inv_proc_o for one cycle. In each strobe vector, bit 0 is the data side (indices 27..29) and bit 1 is the instruction side (indices 30..32). At most one strobe bit is high in any cycle.
- R10: A write to index 29 or 32 pulses inv_one_o on the matching side for one cycle. The same cycle, inv_addr_o holds the written value and inv_asn_o holds the current ASN field: bits 63:57 of index 22 on the data side, bits 10:4 of index 21 on the instruction side.
- R11: Read data, err_o and the strobes appear in the cycle after the request. Scratch indices 0..7 and index 9 store all 64 bits.
- R12: Legal accesses leave err_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| idx_i | input | 6 | Register index |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Registered read data |
| err_o | output | 1 | Access error, one cycle after request |
| inv_all_o | output | 2 | Invalidate-all strobe {instr, data} |
| inv_proc_o | output | 2 | Invalidate-by-process strobe {instr, data} |
| inv_one_o | output | 2 | Single-entry invalidate strobe {instr, data} |
| inv_addr_o | output | 64 | Address for single-entry invalidate |
| inv_asn_o | output | 7 | ASN for single-entry invalidate |

## Verification
Every result of this block is due exactly one clock after its request: the read data, the error flag and all three strobe vectors. The bench raises a request at a falling edge and keeps it for one rising edge. It samples every output at the next falling edge. Only the strobes are then sampled once more a cycle later, which shows that they have dropped. The cycle-counter checks compare two reads whose requests are a known number of rising edges apart, so they do not depend on the counter's absolute value.

// File: rtl/core_ctl_regs_pkg.sv
package core_ctl_regs_pkg;
  localparam int DW    = 64;
  localparam int IDX_W = 6;
  localparam int CNT_W = 32;
  localparam int N_SCR = 8;

  localparam int I_BASE    = N_SCR;
  localparam int I_MCTL    = N_SCR + 1;
  localparam int I_TRAP    = N_SCR + 2;
  localparam int I_AREQ    = N_SCR + 3;
  localparam int I_AEN     = N_SCR + 4;
  localparam int I_IMODE   = N_SCR + 5;
  localparam int I_DMODE   = N_SCR + 6;
  localparam int I_ICTL    = N_SCR + 7;
  localparam int I_IVPT    = N_SCR + 8;
  localparam int I_DVPT    = N_SCR + 9;
  localparam int I_CTEST   = N_SCR + 10;
  localparam int I_CMODE   = N_SCR + 11;
  localparam int I_MMODE   = N_SCR + 12;
  localparam int I_IASN    = N_SCR + 13;
  localparam int I_DASN    = N_SCR + 14;
  localparam int I_XSUM    = N_SCR + 15;
  localparam int I_XMASK   = N_SCR + 16;
  localparam int I_CYC     = N_SCR + 17;
  localparam int I_FID     = N_SCR + 18;
  localparam int I_DINV_A  = N_SCR + 19;
  localparam int I_DINV_P  = N_SCR + 20;
  localparam int I_DINV_1  = N_SCR + 21;
  localparam int I_IINV_A  = N_SCR + 22;
  localparam int I_IINV_P  = N_SCR + 23;
  localparam int I_IINV_1  = N_SCR + 24;
  localparam int NUM_REGS  = N_SCR + 25;

  typedef enum logic [2:0] {
    K_NONE, K_RW, K_RO, K_WO_ZERO, K_WO_KEEP, K_CLR
  } kind_e;

  function automatic logic [DW-1:0] reset_val(input int i, input logic [DW-1:0] base);
    if (i == I_BASE)      return base;
    else if (i == I_MCTL) return 64'h6;
    else                  return '0;
  endfunction
endpackage

// File: rtl/core_ctl_regs_dec.sv
module core_ctl_regs_dec
  import core_ctl_regs_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output kind_e            kind_o,
  output logic [DW-1:0]    wmask_o
);
  always_comb begin
    kind_o  = K_RW;
    wmask_o = '1;
    if (int'(idx_i) >= N_SCR) begin
      case (int'(idx_i))
        I_BASE, I_MCTL, I_CYC: ;
        I_TRAP:            wmask_o = ~64'h2;
        I_AREQ, I_AEN:     wmask_o = 64'hf;
        I_IMODE, I_DMODE:  wmask_o = 64'h18;
        I_ICTL:            wmask_o = 64'hff_ffff_0300;
        I_IVPT, I_DVPT:    wmask_o = 64'hffff_ffff_c000_0000;
        I_CTEST:           wmask_o = 64'h1ffb;
        I_CMODE, I_MMODE:  wmask_o = 64'h3f;
        I_IASN:            wmask_o = 64'h7f0;
        I_DASN:            wmask_o = 64'hfe00_0000_0000_0000;
        I_XSUM, I_XMASK:   kind_o  = K_CLR;
        I_FID:             kind_o  = K_RO;
        I_DINV_A, I_DINV_P,
        I_IINV_A, I_IINV_P: kind_o = K_WO_ZERO;
        I_DINV_1, I_IINV_1: kind_o = K_WO_KEEP;
        default: begin
          kind_o  = K_NONE;
          wmask_o = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/core_ctl_regs_cnt.sv
module core_ctl_regs_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + W'(1);
endmodule

// File: rtl/core_ctl_regs_inval.sv
module core_ctl_regs_inval
  import core_ctl_regs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [6:0]       dasn_i,
  input  logic [6:0]       iasn_i,
  output logic [1:0]       all_o,
  output logic [1:0]       proc_o,
  output logic [1:0]       one_o,
  output logic [DW-1:0]    addr_o,
  output logic [6:0]       asn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      all_o  <= '0;
      proc_o <= '0;
      one_o  <= '0;
      addr_o <= '0;
      asn_o  <= '0;
    end else begin
      all_o  <= '0;
      proc_o <= '0;
      one_o  <= '0;
      if (fire_i) begin
        case (int'(idx_i))
          I_DINV_A: all_o  <= 2'b01;
          I_IINV_A: all_o  <= 2'b10;
          I_DINV_P: proc_o <= 2'b01;
          I_IINV_P: proc_o <= 2'b10;
          I_DINV_1: begin
            one_o  <= 2'b01;
            addr_o <= wdata_i;
            asn_o  <= dasn_i;
          end
          I_IINV_1: begin
            one_o  <= 2'b10;
            addr_o <= wdata_i;
            asn_o  <= iasn_i;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/core_ctl_regs.sv
module core_ctl_regs
  import core_ctl_regs_pkg::*;
#(
  parameter logic [63:0] PAL_BASE_RST = 64'h8000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic         we_i,
  input  logic [5:0]   idx_i,
  input  logic [63:0]  wdata_i,
  output logic [63:0]  rdata_o,
  output logic         err_o,
  output logic [1:0]   inv_all_o,
  output logic [1:0]   inv_proc_o,
  output logic [1:0]   inv_one_o,
  output logic [63:0]  inv_addr_o,
  output logic [6:0]   inv_asn_o
);
  kind_e          kind;
  logic [DW-1:0]  wmask, wr_val, rd_val;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]  regs [NUM_REGS];
  logic           wr_ok, rd_ok;

  core_ctl_regs_dec u_dec (.idx_i(idx_i), .kind_o(kind), .wmask_o(wmask));
  core_ctl_regs_cnt #(.W(CNT_W)) u_cnt (.clk_i(clk_i), .rst_ni(rst_ni), .cnt_o(cnt));

  assign wr_ok  = req_i && we_i && (kind != K_NONE) && (kind != K_RO);
  assign rd_ok  = req_i && !we_i && (kind == K_RW || kind == K_RO || kind == K_CLR);
  assign wr_val = (kind == K_CLR || kind == K_WO_ZERO) ? '0 : (wdata_i & wmask);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                q <= reset_val(g, PAL_BASE_RST);
      else if (wr_ok && int'(idx_i) == g)         q <= wr_val;
    assign regs[g] = q;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(idx_i) == i) rd_val = regs[i];
    if (int'(idx_i) == I_CYC) rd_val = {regs[I_CYC][DW-1:CNT_W], cnt};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= req_i && !(we_i ? wr_ok : rd_ok);
      if (req_i && !we_i) rdata_o <= rd_ok ? rd_val : '0;
    end
  end

  core_ctl_regs_inval u_inval (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (wr_ok),
    .idx_i  (idx_i),
    .wdata_i(wdata_i),
    .dasn_i (regs[I_DASN][63:57]),
    .iasn_i (regs[I_IASN][10:4]),
    .all_o  (inv_all_o),
    .proc_o (inv_proc_o),
    .one_o  (inv_one_o),
    .addr_o (inv_addr_o),
    .asn_o  (inv_asn_o)
  );
endmodule

// File: rtl/core_ctl_regs_chk.sv
module core_ctl_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [5:0]  idx_i,
  input logic [63:0] rdata_o,
  input logic        err_o,
  input logic [1:0]  inv_all_o,
  input logic [1:0]  inv_proc_o,
  input logic [1:0]  inv_one_o
);
  // R8
  unmapped_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && idx_i >= 6'd33 |=> err_o && (we_i || rdata_o == 64'h0));
  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({inv_all_o, inv_proc_o, inv_one_o}));
  // R11
  strobe_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{inv_all_o, inv_proc_o, inv_one_o}) |-> $past(req_i && we_i));
  // R2
  trap_bit1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && idx_i == 6'd10 |=> !rdata_o[1]);
  // R3
  mode_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && (idx_i == 6'd13 || idx_i == 6'd14) |=> (rdata_o & ~64'h18) == 64'h0);
  // R12
  scratch_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && idx_i < 6'd8 |=> !err_o);
endmodule

bind core_ctl_regs core_ctl_regs_chk chk_i (.*);

// File: tb/core_ctl_regs_tb_top.sv
module core_ctl_regs_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  idx = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata, inv_addr;
  logic        err;
  logic [1:0]  inv_all, inv_proc, inv_one;
  logic [6:0]  inv_asn;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  core_ctl_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .idx_i(idx), .wdata_i(wdata),
    .rdata_o(rdata), .err_o(err), .inv_all_o(inv_all), .inv_proc_o(inv_proc),
    .inv_one_o(inv_one), .inv_addr_o(inv_addr), .inv_asn_o(inv_asn)
  );

  task automatic chk(input string r, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic do_wr(input logic [5:0] i, input logic [63:0] v, output logic e);
    @(negedge clk); req = 1; we = 1; idx = i; wdata = v;
    @(negedge clk); req = 0; we = 0; e = err;
  endtask

  task automatic do_rd(input logic [5:0] i, output logic [63:0] d, output logic e);
    @(negedge clk); req = 1; we = 0; idx = i;
    @(negedge clk); req = 0; d = rdata; e = err;
  endtask

  task automatic wr_rd(input string r, input logic [5:0] i, input logic [63:0] v, input logic [63:0] exp);
    logic e; logic [63:0] d;
    do_wr(i, v, e);
    chk({r, " write err"}, 64'(e), 64'h0);
    do_rd(i, d, e);
    chk(r, d, exp);
    chk({r, " read err"}, 64'(e), 64'h0);
  endtask

  task automatic t_reset;
    logic [63:0] d; logic e;
    for (int i = 0; i <= 26; i++) begin
      if (i == 25) continue;
      do_rd(6'(i), d, e);
      chk("R1 reset value", d, i == 8 ? 64'h8000 : (i == 9 ? 64'h6 : 64'h0));
      chk("R12 legal read", 64'(e), 64'h0);
    end
  endtask

  task automatic t_masks;
    wr_rd("R11 scratch", 6'd0, 64'hdead_beef_cafe_f00d, 64'hdead_beef_cafe_f00d);
    wr_rd("R11 scratch", 6'd7, 64'h0123_4567_89ab_cdef, 64'h0123_4567_89ab_cdef);
    wr_rd("R11 mctl", 6'd9, 64'hffff_0000_ffff_0001, 64'hffff_0000_ffff_0001);
    wr_rd("R2 trap", 6'd10, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_fffd);
    wr_rd("R3 areq", 6'd11, 64'hffff_ffff_ffff_ffff, 64'hf);
    wr_rd("R3 aen", 6'd12, 64'h1234_5678_9abc_defa, 64'ha);
    wr_rd("R3 imode", 6'd13, 64'hffff_ffff_ffff_ffff, 64'h18);
    wr_rd("R3 dmode", 6'd14, 64'h10, 64'h10);
    wr_rd("R4 ictl", 6'd15, '1, 64'hff_ffff_0300);
    wr_rd("R4 ivpt", 6'd16, '1, 64'hffff_ffff_c000_0000);
    wr_rd("R4 dvpt", 6'd17, 64'h1234_5678_ffff_ffff, 64'h1234_5678_c000_0000);
    wr_rd("R4 ctest", 6'd18, '1, 64'h1ffb);
    wr_rd("R4 cmode", 6'd19, '1, 64'h3f);
    wr_rd("R4 mmode", 6'd20, 64'h55, 64'h15);
    wr_rd("R4 iasn", 6'd21, '1, 64'h7f0);
    wr_rd("R4 dasn", 6'd22, '1, 64'hfe00_0000_0000_0000);
  endtask

  task automatic t_clear;
    wr_rd("R5 xsum", 6'd23, '1, 64'h0);
    wr_rd("R5 xmask", 6'd24, 64'h8000_0000_0000_0001, 64'h0);
  endtask

  task automatic t_cycle;
    logic [63:0] a, b; logic e;
    do_wr(6'd25, 64'hdead_beef_1234_5678, e);
    chk("R6 write err", 64'(e), 64'h0);
    do_rd(6'd25, a, e);
    chk("R6 upper half", a[63:32], 64'hdead_beef);
    do_rd(6'd25, b, e);
    chk("R6 count step 2", 64'(b[31:0] - a[31:0]), 64'd2);
    repeat (5) @(negedge clk);
    do_rd(6'd25, a, e);
    chk("R6 count step 7", 64'(a[31:0] - b[31:0]), 64'd7);
  endtask

  task automatic t_illegal;
    logic [63:0] d; logic e;
    do_wr(6'd26, '1, e);
    chk("R7 ro write err", 64'(e), 64'h1);
    do_rd(6'd26, d, e);
    chk("R7 ro unchanged", d, 64'h0);
    do_rd(6'd0, d, e);
    do_rd(6'd27, d, e);
    chk("R7 wo read err", 64'(e), 64'h1);
    chk("R7 wo read data", d, 64'h0);
    do_rd(6'd29, d, e);
    chk("R7 wo read err", 64'(e), 64'h1);
    do_wr(6'd40, 64'h1111, e);
    chk("R8 unmapped write err", 64'(e), 64'h1);
    do_wr(6'd63, 64'h2222, e);
    chk("R8 unmapped write err", 64'(e), 64'h1);
    do_rd(6'd0, d, e);
    chk("R8 no state change", d, 64'hdead_beef_cafe_f00d);
    do_rd(6'd40, d, e);
    chk("R8 unmapped read err", 64'(e), 64'h1);
    chk("R8 unmapped read data", d, 64'h0);
  endtask

  task automatic strobe(input string r, input logic [5:0] i, input logic [63:0] v,
                        input logic [1:0] ea, input logic [1:0] ep, input logic [1:0] eo);
    logic e;
    do_wr(i, v, e);
    chk({r, " err"}, 64'(e), 64'h0);
    chk({r, " all"}, 64'(inv_all), 64'(ea));
    chk({r, " proc"}, 64'(inv_proc), 64'(ep));
    chk({r, " one"}, 64'(inv_one), 64'(eo));
    @(negedge clk);
    chk({r, " drop"}, 64'({inv_all, inv_proc, inv_one}), 64'h0);
  endtask

  task automatic t_inval;
    logic e;
    strobe("R9 d all", 6'd27, '1, 2'b01, 2'b00, 2'b00);
    strobe("R9 i all", 6'd30, '1, 2'b10, 2'b00, 2'b00);
    strobe("R9 d proc", 6'd28, 64'h5, 2'b00, 2'b01, 2'b00);
    strobe("R9 i proc", 6'd31, 64'h5, 2'b00, 2'b10, 2'b00);
    do_wr(6'd22, 64'h5a00_0000_0000_0000, e);
    do_wr(6'd21, 64'h3a5, e);
    strobe("R10 d one", 6'd29, 64'h1234_5000, 2'b00, 2'b00, 2'b01);
    do_wr(6'd29, 64'h1234_5000, e);
    chk("R10 d addr", inv_addr, 64'h1234_5000);
    chk("R10 d asn", 64'(inv_asn), 64'h2d);
    do_wr(6'd32, 64'hffff_8000_0000_2000, e);
    chk("R10 i one", 64'(inv_one), 64'h2);
    chk("R10 i addr", inv_addr, 64'hffff_8000_0000_2000);
    chk("R10 i asn", 64'(inv_asn), 64'h3a);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 err idle", 64'(err), 64'h0);
    t_reset;
    t_masks;
    t_clear;
    t_cycle;
    t_illegal;
    t_inval;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule